// File: doc/BRIEF.md
# Three-Line Instruction Prefetch Buffer

This block sits between an instruction decode stage and a slow instruction memory. It keeps three instruction lines of eight words each. Each line carries its own line-address tag, and any line may hold any address, so a lookup compares against all three tags at once. Decode presents a fetch address each cycle. One cycle later the block returns the instruction with a valid flag. If the flag is low, decode must keep presenting the address until the data arrives.

Lines are filled from three sources. A decode fetch that misses raises a demand fill. Decode may also pass a line address for a likely branch or return target as a hint, which fills a line in the background without holding decode up. Every fetch that hits queues a read-ahead of the following line. Line reads go to memory through a valid/ready request channel, and the whole line comes back on a response strobe after a long, variable delay, typically about ten cycles.

All inputs are captured in flops. Every output is driven from registered state, so no path runs combinationally from an input to an output.

Top module: `ifetch_linebuf`

## Requirements
- R1: After reset all three lines are empty, and `insn_valid` and `mem_req_valid` are low.
- R2: A fetch presented in cycle k is answered in cycle k+1. `insn_valid` is high only when the line `fetch_addr>>3` is held. `insn_data` is word `fetch_addr[2:0]` of that line, where word i occupies bits [32i+31:32i] of the returned line.
- R3: A fetch whose line is absent keeps `insn_valid` low and causes a memory read of line `fetch_addr>>3`. The fetch is answered once that line is stored.
- R4: A fetch that hits line L queues a read-ahead of line L+1, modulo 2^LINE_W.
- R5: A pulse on `hint_valid` queues a fill of line `hint_line`. A hint never blocks a fetch. A fetch to a hinted line that has already arrived hits in its first cycle.
- R6: When a read is issued, a waiting demand miss goes before a queued hint, and a queued hint goes before a queued read-ahead. Only one read is outstanding at a time.
- R7: A hint or read-ahead whose line is already held, or is already being read, causes no memory read.
- R8: An empty line is filled first. Otherwise the least recently used line is replaced, where a fetch hit or a fill counts as a use. The line chosen for a read in flight is never chosen again.
- R9: `mem_req_valid` stays high, with `mem_req_line` unchanged, until `mem_req_ready` is seen. The response is taken on the cycle `mem_rsp_valid` is high and carries no back-pressure.
- R10: A change on `fetch_addr` or `fetch_valid` inside a cycle leaves `insn_valid` and `insn_data` unchanged until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Decode presents a fetch address |
| fetch_addr | input | ADDR_W (16) | Instruction word address |
| insn_valid | output | 1 | Previous cycle's fetch hit; data valid |
| insn_data | output | INSN_W (32) | Instruction word for previous cycle's fetch |
| hint_valid | input | 1 | Speculative fill hint strobe |
| hint_line | input | LINE_W (13) | Line address to fill speculatively |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_W (13) | Line address to read |
| mem_rsp_valid | input | 1 | Line data returned |
| mem_rsp_data | input | LINE_BITS (256) | Eight words of the line, word 0 in the low bits |

## Verification
The assertions assume that memory sends exactly one `mem_rsp_valid` pulse for each accepted request, and never before the handshake cycle. They also assume that `mem_req_ready` has no effect while `mem_req_valid` is low. The bench memory model enforces both. It accepts a request only while nothing is in flight, and it returns the line no sooner than two cycles after the handshake. Its latency and its ready stalls are random, within bounds that the directed tests narrow down.

// File: rtl/ipf_pkg.sv
`timescale 1ns/1ps
package ipf_pkg;
  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT} fill_state_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_DEMAND, SRC_HINT, SRC_AHEAD} fill_src_e;
endpackage

// File: rtl/ipf_lru.sv
`timescale 1ns/1ps
module ipf_lru #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     line_valid,
  output logic [IDX_W-1:0] victim_idx
);
  // age 0 = most recent; ages always form a permutation of 0..N-1
  logic [IDX_W-1:0] age_q [N];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) age_q[i] <= IDX_W'(i);
      else if (touch_en) begin
        if (touch_idx == IDX_W'(i))           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic             found;
    logic [IDX_W-1:0] best;
    found      = 1'b0;
    best       = '0;
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!line_valid[i] && !found) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] >= best) begin
          best       = age_q[i];
          victim_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/ipf_line_store.sv
`timescale 1ns/1ps
module ipf_line_store #(
  parameter int N      = 3,
  parameter int LINE_W = 13,
  parameter int WORDS  = 8,
  parameter int INSN_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fill_en,
  input  logic [IDX_W-1:0]             fill_idx,
  input  logic [LINE_W-1:0]            fill_tag,
  input  logic [WORDS*INSN_W-1:0]      fill_data,
  input  logic [LINE_W-1:0]            look_line,
  input  logic [OFF_W-1:0]             look_word,
  output logic                         look_hit,
  output logic [IDX_W-1:0]             look_idx,
  output logic [INSN_W-1:0]            look_data,
  output logic [N-1:0]                 line_valid,
  output logic [N-1:0][LINE_W-1:0]     line_tag
);
  logic [WORDS*INSN_W-1:0] data_q [N];

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) line_valid[g] <= 1'b0;
      else if (fill_en && fill_idx == IDX_W'(g)) line_valid[g] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (fill_en && fill_idx == IDX_W'(g)) begin
        line_tag[g] <= fill_tag;
        data_q[g]   <= fill_data;
      end
    end
  end

  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (line_valid[i] && line_tag[i] == look_line) begin
        look_hit = 1'b1;
        look_idx = IDX_W'(i);
      end
    end
  end

  assign look_data = data_q[look_idx][look_word*INSN_W +: INSN_W];
endmodule

// File: rtl/ipf_fill_ctrl.sv
`timescale 1ns/1ps
module ipf_fill_ctrl
  import ipf_pkg::*;
#(
  parameter int N      = 3,
  parameter int LINE_W = 13,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fq_valid,
  input  logic [LINE_W-1:0]        fq_line,
  input  logic                     fq_hit,
  input  logic                     hint_valid,
  input  logic [LINE_W-1:0]        hint_line,
  input  logic                     ahead_set,
  input  logic [LINE_W-1:0]        ahead_line,
  input  logic [N-1:0]             line_valid,
  input  logic [N-1:0][LINE_W-1:0] line_tag,
  input  logic [IDX_W-1:0]         victim_idx,
  input  logic                     mem_req_ready,
  input  logic                     mem_rsp_valid,
  output logic                     mem_req_valid,
  output logic [LINE_W-1:0]        mem_req_line,
  output logic                     fill_en,
  output logic [IDX_W-1:0]         fill_idx,
  output logic [LINE_W-1:0]        fill_tag
);
  fill_state_e       state_q;
  logic [LINE_W-1:0] req_line_q;
  logic [IDX_W-1:0]  vic_q;
  logic              hp_v, ap_v;
  logic [LINE_W-1:0] hp_line, ap_line;

  logic              busy, hint_res, ahead_res, hint_dup, ahead_dup;
  fill_src_e         src;
  logic [LINE_W-1:0] pick;

  assign busy = (state_q != FS_IDLE);

  always_comb begin
    hint_res  = 1'b0;
    ahead_res = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (line_valid[i] && line_tag[i] == hp_line) hint_res  = 1'b1;
      if (line_valid[i] && line_tag[i] == ap_line) ahead_res = 1'b1;
    end
  end

  assign hint_dup  = hint_res  || (busy && hp_line == req_line_q);
  assign ahead_dup = ahead_res || (busy && ap_line == req_line_q);

  // issue order: demand miss, then hint, then read-ahead
  always_comb begin
    src  = SRC_NONE;
    pick = fq_line;
    if (!busy) begin
      if (fq_valid && !fq_hit)   begin src = SRC_DEMAND; pick = fq_line; end
      else if (hp_v && !hint_res)  begin src = SRC_HINT;   pick = hp_line; end
      else if (ap_v && !ahead_res) begin src = SRC_AHEAD;  pick = ap_line; end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_v <= 1'b0;
      ap_v <= 1'b0;
    end else begin
      if (hint_valid) begin
        hp_v    <= 1'b1;
        hp_line <= hint_line;
      end else if (hp_v && (hint_dup || src == SRC_HINT)) begin
        hp_v <= 1'b0;
      end
      if (ahead_set) begin
        ap_v    <= 1'b1;
        ap_line <= ahead_line;
      end else if (ap_v && (ahead_dup || src == SRC_AHEAD)) begin
        ap_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
    end else begin
      unique case (state_q)
        FS_IDLE: if (src != SRC_NONE) begin
          state_q    <= FS_REQ;
          req_line_q <= pick;
          vic_q      <= victim_idx;
        end
        FS_REQ:  if (mem_req_ready) state_q <= FS_WAIT;
        FS_WAIT: if (mem_rsp_valid) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == FS_REQ);
  assign mem_req_line  = req_line_q;
  assign fill_en       = (state_q == FS_WAIT) && mem_rsp_valid;
  assign fill_idx      = vic_q;
  assign fill_tag      = req_line_q;
endmodule

// File: rtl/ifetch_linebuf.sv
`timescale 1ns/1ps
module ifetch_linebuf #(
  parameter  int ADDR_W     = 16,
  parameter  int INSN_W     = 32,
  parameter  int LINE_WORDS = 8,
  parameter  int NUM_LINES  = 3,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int LINE_W     = ADDR_W - OFF_W,
  localparam int LINE_BITS  = LINE_WORDS * INSN_W,
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_valid,
  input  logic [ADDR_W-1:0]    fetch_addr,
  output logic                 insn_valid,
  output logic [INSN_W-1:0]    insn_data,
  input  logic                 hint_valid,
  input  logic [LINE_W-1:0]    hint_line,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [LINE_W-1:0]    mem_req_line,
  input  logic                 mem_rsp_valid,
  input  logic [LINE_BITS-1:0] mem_rsp_data
);
  logic                        fv_q;
  logic [ADDR_W-1:0]           fa_q;
  logic [LINE_W-1:0]           fq_line;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx, victim_idx, fill_idx;
  logic                        fill_en;
  logic [LINE_W-1:0]           fill_tag;
  logic [NUM_LINES-1:0]        line_valid;
  logic [NUM_LINES-1:0][LINE_W-1:0] line_tag;

  always_ff @(posedge clk) begin
    if (rst) fv_q <= 1'b0;
    else     fv_q <= fetch_valid;
    fa_q <= fetch_addr;
  end

  assign fq_line    = fa_q[ADDR_W-1:OFF_W];
  assign insn_valid = fv_q && hit;

  ipf_line_store #(
    .N(NUM_LINES), .LINE_W(LINE_W), .WORDS(LINE_WORDS),
    .INSN_W(INSN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) i_store (
    .clk(clk), .rst(rst),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(mem_rsp_data),
    .look_line(fq_line), .look_word(fa_q[OFF_W-1:0]),
    .look_hit(hit), .look_idx(hit_idx), .look_data(insn_data),
    .line_valid(line_valid), .line_tag(line_tag)
  );

  ipf_lru #(.N(NUM_LINES), .IDX_W(IDX_W)) i_lru (
    .clk(clk), .rst(rst),
    .touch_en(fill_en || (fv_q && hit)),
    .touch_idx(fill_en ? fill_idx : hit_idx),
    .line_valid(line_valid),
    .victim_idx(victim_idx)
  );

  ipf_fill_ctrl #(.N(NUM_LINES), .LINE_W(LINE_W), .IDX_W(IDX_W)) i_fill (
    .clk(clk), .rst(rst),
    .fq_valid(fv_q), .fq_line(fq_line), .fq_hit(hit),
    .hint_valid(hint_valid), .hint_line(hint_line),
    .ahead_set(fv_q && hit), .ahead_line(fq_line + 1'b1),
    .line_valid(line_valid), .line_tag(line_tag), .victim_idx(victim_idx),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag)
  );
endmodule

// File: rtl/ipf_checker.sv
`timescale 1ns/1ps
module ipf_checker #(
  parameter int LINE_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              insn_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [LINE_W-1:0] mem_req_line,
  input logic              mem_rsp_valid
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!insn_valid && !mem_req_valid));

  p_answer_needs_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    insn_valid |-> $past(fetch_valid));

  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !mem_req_valid);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line)));
endmodule

bind ifetch_linebuf ipf_checker #(.LINE_W(LINE_W)) i_ipf_checker (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .insn_valid(insn_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/test_ifetch_linebuf.sv
`timescale 1ns/1ps
module test_ifetch_linebuf;
  localparam int AW = 16, LW = 13, LB = 256;

  logic          clk = 1'b0, rst = 1'b1;
  logic          fetch_valid = 1'b0, hint_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [LW-1:0] hint_line = '0;
  logic          insn_valid, mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0]   insn_data;
  logic [LW-1:0] mem_req_line;
  logic [LB-1:0] mem_rsp_data = '0;

  int checks = 0, errors = 0;
  int lat_min = 3, lat_max = 16, ready_pct = 70;
  bit mdl_pending = 1'b0;
  int mdl_cnt = 0;
  logic [LW-1:0] mdl_line, req_log [256];
  int req_cnt = 0;

  always #2.5 clk = ~clk;

  ifetch_linebuf i_ifetch_linebuf (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .insn_valid(insn_valid), .insn_data(insn_data),
    .hint_valid(hint_valid), .hint_line(hint_line),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] wd(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  function automatic logic [LB-1:0] line_data(input logic [LW-1:0] l);
    logic [LB-1:0] d;
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = wd({l, 3'(i)});
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory model: one read at a time, random latency and ready stalls
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        mdl_pending = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
        if (mdl_pending) begin
          mdl_cnt--;
          if (mdl_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = line_data(mdl_line);
            mdl_pending   = 1'b0;
          end
        end
        mem_req_ready = 1'b0;
        if (mem_req_valid && !mdl_pending && !mem_rsp_valid) begin
          if ($urandom_range(99) < 32'(ready_pct)) begin
            mem_req_ready = 1'b1;
            mdl_pending   = 1'b1;
            mdl_cnt       = $urandom_range(lat_max, lat_min);
            mdl_line      = mem_req_line;
            req_log[req_cnt % 256] = mem_req_line;
            req_cnt++;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fetch_valid = 1'b0; hint_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (!mem_req_valid && !mdl_pending && !mem_rsp_valid) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic send_hint(input logic [LW-1:0] l);
    @(negedge clk);
    hint_valid = 1'b1; hint_line = l;
    @(negedge clk);
    hint_valid = 1'b0;
  endtask

  task automatic fetch_once(input logic [AW-1:0] a, output logic v, output logic [31:0] d);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    v = insn_valid; d = insn_data;
    fetch_valid = 1'b0;
  endtask

  task automatic fetch_wait(input logic [AW-1:0] a, input string req);
    bit got = 1'b0;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (insn_valid) begin
        got = 1'b1;
        chk(insn_data == wd(a), req, insn_data, wd(a));
      end
    end
    fetch_valid = 1'b0;
    chk(got, req, 0, 1);
  endtask

  initial begin
    logic v;
    logic [31:0] d;
    int base;

    // reset state
    do_reset();
    chk(insn_valid == 1'b0, "R1 insn_valid", insn_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    fetch_once(16'd24, v, d);
    chk(v == 1'b0, "R1 empty lines miss", v, 0);
    wait_idle();

    // hints, duplicates, read-ahead
    do_reset();
    lat_min = 10; lat_max = 10; ready_pct = 100;
    base = req_cnt;
    send_hint(13'd40);
    repeat (3) @(negedge clk);
    send_hint(13'd40);              // in flight: dropped (R7)
    wait_idle();
    send_hint(13'd40);              // resident: dropped (R7)
    repeat (20) @(negedge clk);
    chk(req_cnt - base == 1, "R7 duplicate hints", 64'(req_cnt - base), 1);
    chk(req_log[base % 256] == 13'd40, "R5 hint line read", req_log[base % 256], 40);
    fetch_once(16'(40*8 + 2), v, d);
    chk(v == 1'b1, "R5 hinted line hits first cycle", v, 1);
    chk(d == wd(16'(40*8 + 2)), "R2 word select", d, wd(16'(40*8 + 2)));
    wait_idle();
    chk(req_log[(base + 1) % 256] == 13'd41, "R4 read-ahead line", req_log[(base + 1) % 256], 41);
    fetch_once(16'(40*8 + 7), v, d);
    chk(v == 1'b1 && d == wd(16'(40*8 + 7)), "R2 last word", d, wd(16'(40*8 + 7)));
    wait_idle();
    chk(req_cnt - base == 2, "R7 resident read-ahead dropped", 64'(req_cnt - base), 2);

    // registered inputs: mid-cycle change has no effect (R10), then miss stalls (R3)
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = 16'(40*8 + 5);
    @(negedge clk);
    chk(insn_valid == 1'b1, "R2 hit", insn_valid, 1);
    fetch_addr = 16'(900*8);
    #1;
    chk(insn_valid == 1'b1 && insn_data == wd(16'(40*8 + 5)), "R10 no input-output path",
        insn_data, wd(16'(40*8 + 5)));
    @(negedge clk);
    chk(insn_valid == 1'b0, "R3 miss stalls", insn_valid, 0);
    fetch_valid = 1'b0;
    wait_idle();
    chk(req_log[(req_cnt - 1) % 256] == 13'd900, "R3 demand line read", req_log[(req_cnt - 1) % 256], 900);

    // priority: demand > hint > read-ahead, one outstanding (R6)
    do_reset();
    lat_min = 30; lat_max = 30;
    base = req_cnt;
    send_hint(13'd600);
    repeat (5) @(negedge clk);
    send_hint(13'd700);
    fetch_wait(16'(800*8 + 1), "R3 demand completes");
    wait_idle();
    chk(req_cnt - base == 4, "R6 read count", 64'(req_cnt - base), 4);
    chk(req_log[(base + 1) % 256] == 13'd800, "R6 demand first", req_log[(base + 1) % 256], 800);
    chk(req_log[(base + 2) % 256] == 13'd700, "R6 hint before read-ahead", req_log[(base + 2) % 256], 700);
    chk(req_log[(base + 3) % 256] == 13'd801, "R6 read-ahead last", req_log[(base + 3) % 256], 801);

    // LRU replacement (R8)
    do_reset();
    lat_min = 4; lat_max = 8;
    send_hint(13'd100); wait_idle();
    send_hint(13'd200); wait_idle();
    send_hint(13'd300); wait_idle();
    fetch_once(16'(100*8), v, d);   // touch 100; read-ahead of 101 evicts 200
    chk(v == 1'b1, "R8 filled line hits", v, 1);
    wait_idle();
    chk(req_log[(req_cnt - 1) % 256] == 13'd101, "R4 read-ahead issued", req_log[(req_cnt - 1) % 256], 101);
    fetch_once(16'(100*8 + 1), v, d);
    chk(v == 1'b1, "R8 recently used line kept", v, 1);
    fetch_once(16'(200*8), v, d);
    chk(v == 1'b0, "R8 least recent line evicted", v, 0);
    wait_idle();

    // constrained random run
    do_reset();
    lat_min = 2; lat_max = 16; ready_pct = 70;
    begin
      bit pv = 1'b0;
      logic [AW-1:0] pa = '0, cur = 16'd0;
      int stall = 0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
        @(negedge clk);
        if (pv) begin
          if (insn_valid) begin
            chk(insn_data == wd(pa), "R2 random data", insn_data, wd(pa));
            stall = 0;
          end else begin
            stall++;
            if (stall > 120) begin
              chk(1'b0, "R3 random progress", stall, 0);
              stall = 0;
            end
          end
        end
        if (!(pv && !insn_valid)) begin
          int r = $urandom_range(99);
          if (r < 80)      begin cur = pa + 1'b1; fetch_valid = 1'b1; end
          else if (r < 92) begin cur = 16'($urandom_range(511)); fetch_valid = 1'b1; end
          else             fetch_valid = 1'b0;
          if (!pv && fetch_valid) cur = pa;
          fetch_addr = cur;
        end
        hint_valid = ($urandom_range(99) < 8);
        hint_line  = 13'($urandom_range(63));
        pv = fetch_valid;
        pa = fetch_addr;
      end
      fetch_valid = 1'b0;
      hint_valid  = 1'b0;
    end
    wait_idle();
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule